// File: doc/BRIEF.md
# Second-Order Noise-Shaping Bit-Stream Modulator

This block converts a stream of 16-bit two's-complement samples into a single-bit pulse-density stream. A downstream analog smoothing filter turns that stream into a voltage. Two cascaded integrators accumulate the difference between the input and a full-scale feedback value. A one-bit quantizer looks at the sign of the second integrator and picks the feedback level for the next step. The quantization error is shaped by (1 - z^-1)^2 and pushed out of the signal band.

The block runs from a fast system clock. An internal divider produces a modulator tick once every `CLK_DIV` enabled clocks, which is 13 by default; from a 13 MHz clock that gives a 1 MHz bit rate. The upstream interpolation stage presents the sample on `sample_in`, and the block samples it only on a tick. The clock-enable input `run_en` freezes the divider and the loop without losing state. A synchronous reset clears the divider, both integrators and the outputs.

Top module: `dsm2_modulator`

## Requirements
- R1: While `rst` is high at a clock edge, the next cycle shows `bit_out` = 0 and `bit_tick` = 0, and the divider and both integrators are cleared. The first bit after reset is therefore 1, because a zero second integrator counts as non-negative.
- R2: With `run_en` held high, a modulator tick occurs on every `CLK_DIV`-th clock. The first tick comes on the `CLK_DIV`-th enabled clock after reset. `bit_tick` is high for exactly the one cycle that follows each tick edge.
- R3: A clock with `run_en` low advances neither the divider nor the integrators, and `bit_tick` is 0 in the cycle after it.
- R4: On a tick, `bit_out` becomes 1 when the second integrator is >= 0 and 0 when it is negative. `bit_out` changes at no other time. A 1 selects feedback +32768 and a 0 selects feedback -32768.
- R5: On a tick, with feedback f taken from the bit chosen in that same tick, the updates are: first integrator += sample - f; second integrator += (previous first integrator) - 2f.
- R6: Both integrators are `ACC_W` bits wide, with `ACC_W` at least 20. Each saturates at -2^(ACC_W-1) and 2^(ACC_W-1)-1 instead of wrapping.
- R7: For a constant input x, the mean of the output bits over 2000 ticks, with 1 counted as +1 and 0 as -1, lies within 0.03 of x/32768.
- R8: `sample_in` is read only at a tick. Its value on any other clock has no effect on later output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| run_en | input | 1 | Clock enable for divider and loop |
| sample_in | input | 16 | Two's-complement input sample |
| bit_out | output | 1 | Modulated bit, held between ticks |
| bit_tick | output | 1 | One-cycle strobe marking a new bit |

## Verification
The condition hardest to reach from the ports is an integrator sitting at, or next to, its saturation limit. The loop keeps both integrators small for moderate inputs, so only long stretches of full-scale input, and sudden swings between the two extremes, push the second integrator far out. The bench holds each extreme for hundreds of ticks and alternates between them. Its behavioural model computes the exact integrator values, with saturation, so any departure in the bit sequence is caught on the very tick where it occurs.

// File: rtl/dsm2_pkg.sv
package dsm2_pkg;

    localparam int SAMPLE_W = 16;
    localparam int FB_W     = SAMPLE_W + 1;   // holds +/- 2^(SAMPLE_W-1)
    localparam int ERR1_W   = SAMPLE_W + 2;   // sample - feedback

    typedef enum logic {
        LVL_LOW  = 1'b0,
        LVL_HIGH = 1'b1
    } dsm2_level_e;

    typedef struct packed {
        dsm2_level_e              level;
        logic signed [FB_W-1:0]   fb;
    } dsm2_decision_t;

    function automatic logic signed [FB_W-1:0] level_to_fb(input dsm2_level_e lvl);
        logic signed [FB_W-1:0] full;
        full = {2'b01, {(SAMPLE_W-1){1'b0}}};
        return (lvl == LVL_HIGH) ? full : -full;
    endfunction

endpackage

// File: rtl/dsm2_tick_gen.sv
module dsm2_tick_gen #(
    parameter int DIV = 13
) (
    input  logic clk,
    input  logic rst,
    input  logic run_en,
    output logic tick
);
    localparam int CNT_W = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DIV - 1);

    logic [CNT_W-1:0] cnt;

    assign tick = run_en && (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (run_en)
            cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
    end

    generate
        if (DIV > 1) begin : g_spacing
            AST_TICK_ISOLATED: assert property (@(posedge clk) disable iff (rst)
                tick |=> !tick);                                   // R2
        end
    endgenerate

endmodule

// File: rtl/dsm2_integrator.sv
module dsm2_integrator #(
    parameter int ACC_W = 22,
    parameter int ADD_W = 18
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    en,
    input  logic signed [ADD_W-1:0] addend,
    output logic signed [ACC_W-1:0] acc
);
    localparam int SUM_W = ((ACC_W > ADD_W) ? ACC_W : ADD_W) + 1;
    localparam logic signed [SUM_W-1:0] LIM_HI =
        {{(SUM_W-ACC_W+1){1'b0}}, {(ACC_W-1){1'b1}}};
    localparam logic signed [SUM_W-1:0] LIM_LO =
        {{(SUM_W-ACC_W+1){1'b1}}, {(ACC_W-1){1'b0}}};
    localparam logic signed [ACC_W-1:0] ACC_HI = {1'b0, {(ACC_W-1){1'b1}}};
    localparam logic signed [ACC_W-1:0] ACC_LO = {1'b1, {(ACC_W-1){1'b0}}};

    logic signed [SUM_W-1:0] acc_x, add_x, sum;
    logic signed [ACC_W-1:0] nxt;

    always_comb begin
        acc_x = {{(SUM_W-ACC_W){acc[ACC_W-1]}}, acc};
        add_x = {{(SUM_W-ADD_W){addend[ADD_W-1]}}, addend};
        sum   = acc_x + add_x;
        if (sum > LIM_HI)
            nxt = ACC_HI;
        else if (sum < LIM_LO)
            nxt = ACC_LO;
        else
            nxt = sum[ACC_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst)
            acc <= '0;
        else if (en)
            acc <= nxt;
    end

    AST_SAT_HOLD_HI: assert property (@(posedge clk) disable iff (rst)
        (en && acc == ACC_HI && !addend[ADD_W-1]) |=> (acc == ACC_HI));  // R6
    AST_SAT_HOLD_LO: assert property (@(posedge clk) disable iff (rst)
        (en && acc == ACC_LO && addend[ADD_W-1]) |=> (acc == ACC_LO));   // R6

endmodule

// File: rtl/dsm2_quantizer.sv
module dsm2_quantizer #(
    parameter int ACC_W = 22
) (
    input  logic signed [ACC_W-1:0] level_in,
    output dsm2_pkg::dsm2_decision_t decision
);
    import dsm2_pkg::*;

    always_comb begin
        decision.level = level_in[ACC_W-1] ? LVL_LOW : LVL_HIGH;
        decision.fb    = level_to_fb(decision.level);
    end

endmodule

// File: rtl/dsm2_modulator.sv
module dsm2_modulator #(
    parameter int ACC_W   = 22,
    parameter int CLK_DIV = 13
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        run_en,
    input  logic [15:0] sample_in,
    output logic        bit_out,
    output logic        bit_tick
);
    import dsm2_pkg::*;

    localparam int ERR2_W = ACC_W + 2;

    logic                     tick;
    dsm2_decision_t           dec;
    logic signed [ACC_W-1:0]  int1, int2;
    logic signed [ERR1_W-1:0] err1;
    logic signed [ERR2_W-1:0] err2;

    dsm2_tick_gen #(.DIV(CLK_DIV)) i_tick (
        .clk(clk), .rst(rst), .run_en(run_en), .tick(tick)
    );

    dsm2_quantizer #(.ACC_W(ACC_W)) i_quant (
        .level_in(int2), .decision(dec)
    );

    always_comb begin
        err1 = $signed({{(ERR1_W-SAMPLE_W){sample_in[SAMPLE_W-1]}}, sample_in})
             - $signed({{(ERR1_W-FB_W){dec.fb[FB_W-1]}}, dec.fb});
        err2 = $signed({{2{int1[ACC_W-1]}}, int1})
             - $signed({{(ERR2_W-FB_W-1){dec.fb[FB_W-1]}}, dec.fb, 1'b0});
    end

    dsm2_integrator #(.ACC_W(ACC_W), .ADD_W(ERR1_W)) i_int1 (
        .clk(clk), .rst(rst), .en(tick), .addend(err1), .acc(int1)
    );

    dsm2_integrator #(.ACC_W(ACC_W), .ADD_W(ERR2_W)) i_int2 (
        .clk(clk), .rst(rst), .en(tick), .addend(err2), .acc(int2)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            bit_out  <= 1'b0;
            bit_tick <= 1'b0;
        end else begin
            bit_tick <= tick;
            if (tick)
                bit_out <= dec.level;
        end
    end

    AST_CLEAR_ON_RESET: assert property (@(posedge clk)
        rst |=> (!bit_out && !bit_tick));                            // R1
    AST_IDLE_NO_STROBE: assert property (@(posedge clk) disable iff (rst)
        !run_en |=> !bit_tick);                                      // R3
    AST_BIT_ONLY_ON_STROBE: assert property (@(posedge clk) disable iff (rst)
        !$stable(bit_out) |-> bit_tick);                             // R4

endmodule

// File: tb/test_dsm2_modulator.sv
`timescale 1ns/1ps
module test_dsm2_modulator;
    localparam int ACC_W = 20;
    localparam int DIV   = 13;
    localparam longint HI = (64'sd1 <<< (ACC_W-1)) - 1;
    localparam longint LO = -(64'sd1 <<< (ACC_W-1));

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        run_en = 1'b0;
    logic [15:0] sample_in = '0;
    logic        bit_out, bit_tick;

    int vectors = 0;
    int fails = 0;
    string req = "R1";

    // reference model state
    int     m_cnt = 0;
    longint m_i1 = 0, m_i2 = 0;
    bit     m_bit = 0, m_strobe = 0;

    // average tracking for R7
    int acc_sum = 0, acc_n = 0;
    bit track = 0;

    always #2.5 clk = ~clk;

    dsm2_modulator #(.ACC_W(ACC_W), .CLK_DIV(DIV)) i_dsm2_modulator (
        .clk(clk), .rst(rst), .run_en(run_en), .sample_in(sample_in),
        .bit_out(bit_out), .bit_tick(bit_tick)
    );

    function automatic longint clampv(input longint v);
        if (v > HI) return HI;
        if (v < LO) return LO;
        return v;
    endfunction

    task automatic model_step();
        longint x, f, n1, n2;
        bit y;
        if (rst) begin
            m_cnt = 0; m_i1 = 0; m_i2 = 0; m_bit = 0; m_strobe = 0;
        end else if (run_en) begin
            if (m_cnt == DIV-1) begin
                m_cnt = 0;
                x = longint'($signed(sample_in));
                y = (m_i2 >= 0);
                f = y ? 32768 : -32768;
                n1 = clampv(m_i1 + x - f);
                n2 = clampv(m_i2 + m_i1 - 2*f);
                m_i1 = n1; m_i2 = n2; m_bit = y; m_strobe = 1;
            end else begin
                m_cnt++;
                m_strobe = 0;
            end
        end else begin
            m_strobe = 0;
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        model_step();
        @(negedge clk);
        vectors++;
        if (bit_out !== m_bit || bit_tick !== m_strobe) begin
            fails++;
            $display("FAIL %s: bit_out=%0b bit_tick=%0b expected %0b %0b at %0t",
                     req, bit_out, bit_tick, m_bit, m_strobe, $time);
        end
        if (track && bit_tick) begin
            acc_sum += bit_out ? 1 : -1;
            acc_n++;
        end
    endtask

    task automatic run_ticks(input int n, input logic [15:0] x);
        sample_in = x;
        repeat (n * DIV) cyc();
    endtask

    task automatic avg_check(input int x);
        real mean, target, d;
        sample_in = 16'(x);
        repeat (200 * DIV) cyc();      // settle
        acc_sum = 0; acc_n = 0; track = 1;
        repeat (2000 * DIV) cyc();
        track = 0;
        mean = real'(acc_sum) / real'(acc_n);
        target = real'(x) / 32768.0;
        d = mean - target;
        if (d < 0.0) d = -d;
        vectors++;
        if (d > 0.03 || acc_n != 2000) begin
            fails++;
            $display("FAIL R7: mean=%f over %0d ticks expected %f", mean, acc_n, target);
        end
    endtask

    initial begin
        #(190000 * 5);
        fails++;
        $display("FAIL watchdog: run did not complete, expected end before timeout");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        int lcg;
        // R1: reset state
        req = "R1";
        repeat (5) cyc();
        rst = 0; run_en = 1;
        // R1/R2: first ticks after reset, cadence at idle input
        req = "R2";
        run_ticks(300, 16'd0);
        // R3: gating with run_en in irregular pattern
        req = "R3";
        sample_in = 16'd9000;
        for (int k = 0; k < 600; k++) begin
            run_en = (k % 7 != 3) && (k % 11 != 5);
            cyc();
        end
        run_en = 0;
        repeat (40) cyc();
        run_en = 1;
        // R8: sample changes every clock, only tick value counts
        req = "R8";
        lcg = 12345;
        for (int k = 0; k < 500 * DIV; k++) begin
            lcg = lcg * 1103515245 + 12345;
            sample_in = 16'(lcg >>> 9);
            cyc();
        end
        // R4/R5: ramps and mixed values
        req = "R5";
        for (int k = 0; k < 64; k++) run_ticks(10, 16'(k * 1000 - 32000));
        // R6: long full-scale stretches and swings between extremes
        req = "R6";
        run_ticks(800, 16'h8000);
        run_ticks(800, 16'h7FFF);
        for (int k = 0; k < 20; k++) begin
            run_ticks(25, 16'h8000);
            run_ticks(25, 16'h7FFF);
        end
        // R1: reset in the middle of operation
        req = "R1";
        rst = 1;
        repeat (3) cyc();
        rst = 0;
        req = "R4";
        run_ticks(50, 16'd0);
        // R7: average tracking
        req = "R7";
        avg_check(16384);
        avg_check(-8192);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule